// File: doc/BRIEF.md
# Guarded Oscillator and System-Clock Controller

This block is a small register file that steers a high-speed oscillator and the system-clock selection. Software reaches it through a plain write/read port: a write happens when `bus_we` is high at a rising clock edge, and `bus_rdata` shows the addressed register combinationally. The oscillator settings and the system-clock selection are guarded by a lock. Software opens the lock by writing a 16-bit key to a dedicated register, and any other value written there closes it again.

Once software sets the enable bit, an internal counter runs for a programmable number of clock cycles. This models the time the oscillator needs to settle. When the count completes, a sticky ready flag is set. The interrupt output is high while that flag is set and the interrupt enable is on. Software clears the flag by writing 1 to it. The source and divider selections are driven out to a downstream clock multiplexer, and the gain and mode settings are driven out to the oscillator.

Register map: 0 key, 1 oscillator setup, 2 system-clock select, 3 oscillator enable, 4 ready flag, 5 interrupt enable. All other addresses read as zero.

Top module: `clkctl_top`

## Requirements
- R1: A write of 16'h0096 to address 0 unlocks the guarded registers, and a write of any other value to address 0 locks them. Address 0 reads back 1 while unlocked and 0 while locked.
- R2: While locked, writes to address 1 and to address 2 leave both registers and their outputs unchanged.
- R3: After reset the block is locked, all registers read 0, `sys_src` is 0 (internal oscillator), `sys_div` is 0, and `osc_ready` and `osc_irq` are 0.
- R4: Address 1 holds the wait code in bits [2:0]. When bit 0 of address 3 is written 1 while the enable is 0, `osc_ready` rises exactly 2^(4+2*code) clock edges after the edge that captured the write.
- R5: Writing address 4 with bit 0 = 1 clears the ready flag. Writing it with bit 0 = 0 leaves the flag as it was.
- R6: `osc_irq` is 1 exactly when the ready flag is 1 and bit 0 of address 5 is 1.
- R7: Writing 0 to the enable stops the count at once and leaves the flag unchanged. A later write of 1 restarts the full wait from zero.
- R8: Address 1 bits [4:3] drive `osc_gain` and bit 5 drives `osc_mode` (0 crystal/ceramic, 1 internal RC). Address 2 bits [1:0] drive `sys_src`, and bits [3:2] drive `sys_div` (0,1,2,3 mean divide by 1,2,4,8). Each register reads back what was last accepted.
- R9: The enable register (address 3) and the interrupt-enable register (address 5) accept writes whether the block is locked or not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also counted for the settling wait |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| osc_ready | output | 1 | Sticky ready flag |
| osc_irq | output | 1 | Ready interrupt |
| osc_mode | output | 1 | Oscillator mode, 1 = internal RC |
| osc_gain | output | 2 | Inverter gain setting |
| sys_src | output | 2 | System-clock source select |
| sys_div | output | 2 | System-clock divider code |

## Verification
The hardest case to reach is a count that is stopped partway and then restarted. It needs a disable write in the middle of a wait, a long idle period, and a second enable. A counter that resumes instead of restarting would then fire early. Directed sequences set this up with the middle wait code and check the flag one edge before and one edge after the full interval. Random writes, half of them carrying the key, mix the lock state with writes to the guarded registers and check every read-back against a bench model.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int CODE_W = 3;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 16'h0096;

  localparam logic [ADDR_W-1:0] A_KEY    = 3'd0;
  localparam logic [ADDR_W-1:0] A_OSCCFG = 3'd1;
  localparam logic [ADDR_W-1:0] A_SCLK   = 3'd2;
  localparam logic [ADDR_W-1:0] A_OSCEN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd4;
  localparam logic [ADDR_W-1:0] A_IEN    = 3'd5;

  // bit 5 mode, bits 4:3 gain, bits 2:0 wait code
  typedef struct packed {
    logic              mode;
    logic [1:0]        gain;
    logic [CODE_W-1:0] wait_code;
  } osc_cfg_t;

  // bits 3:2 divider, bits 1:0 source
  typedef struct packed {
    logic [1:0] div;
    logic [1:0] src;
  } sclk_cfg_t;
endpackage

// File: rtl/clkctl_rstsync.sv
module clkctl_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/clkctl_prot.sv
module clkctl_prot
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_key,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  logic open_q;
  logic open_d;

  always_comb begin
    open_d = open_q;
    if (wr_key) open_d = (wdata == UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  assign unlocked = open_q;

  // R1
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key && wdata == UNLOCK_KEY) |=> unlocked);
  // R1
  key_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key && wdata != UNLOCK_KEY) |=> !unlocked);
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      unlocked,
  input  logic      wr_cfg,
  input  logic      wr_sclk,
  input  logic      wr_en,
  input  logic      wr_ien,
  input  logic [5:0] wdata,
  output osc_cfg_t  cfg,
  output sclk_cfg_t sclk,
  output logic      osc_en,
  output logic      ien
);
  osc_cfg_t  cfg_q,  cfg_d;
  sclk_cfg_t sclk_q, sclk_d;
  logic      en_q,   en_d;
  logic      ien_q,  ien_d;
  logic      cfg_ce, sclk_ce;

  always_comb begin
    cfg_ce  = wr_cfg  && unlocked;
    sclk_ce = wr_sclk && unlocked;
    cfg_d   = cfg_ce  ? osc_cfg_t'(wdata)       : cfg_q;
    sclk_d  = sclk_ce ? sclk_cfg_t'(wdata[3:0]) : sclk_q;
    en_d    = wr_en   ? wdata[0] : en_q;
    ien_d   = wr_ien  ? wdata[0] : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      sclk_q <= '0;
      en_q   <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      sclk_q <= sclk_d;
      en_q   <= en_d;
      ien_q  <= ien_d;
    end
  end

  assign cfg    = cfg_q;
  assign sclk   = sclk_q;
  assign osc_en = en_q;
  assign ien    = ien_q;

  // R2
  cfg_locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !unlocked) |=> $stable(cfg));
  // R2
  sclk_locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sclk && !unlocked) |=> $stable(sclk));
  // R9
  en_always_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (osc_en == $past(wdata[0])));
endmodule

// File: rtl/clkctl_stab.sv
module clkctl_stab #(
  parameter int WAIT_BASE = 4,
  parameter int WAIT_STEP = 2,
  parameter int CODE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              start,
  input  logic              flag_clr,
  input  logic [CODE_W-1:0] wait_code,
  output logic              ready
);
  localparam int CNT_W = WAIT_BASE + WAIT_STEP * ((1 << CODE_W) - 1) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, limit;
  logic             done_q, done_d;
  logic             flag_q, flag_d;
  logic             running, hit;

  always_comb begin
    limit   = CNT_W'(1) << (WAIT_BASE + WAIT_STEP * int'(wait_code));
    cnt_inc = cnt_q + CNT_W'(1);
    running = osc_en && !done_q && !start;
    hit     = running && (cnt_inc == limit);
    cnt_d   = cnt_q;
    done_d  = done_q;
    if (start) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!osc_en) begin
      done_d = 1'b0;
    end else if (running) begin
      cnt_d  = cnt_inc;
      done_d = hit;
    end
    flag_d = flag_q;
    if (hit)           flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      flag_q <= flag_d;
    end
  end

  assign ready = flag_q;

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !flag_clr) |=> ready);
  // R4
  flag_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> osc_en);
  // R7
  cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int WAIT_BASE = 4,
  parameter int WAIT_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              osc_ready,
  output logic              osc_irq,
  output logic              osc_mode,
  output logic [1:0]        osc_gain,
  output logic [1:0]        sys_src,
  output logic [1:0]        sys_div
);
  logic      rst_ni;
  logic      unlocked;
  osc_cfg_t  cfg;
  sclk_cfg_t sclk;
  logic      osc_en, ien, ready;
  logic      wr_key, wr_cfg, wr_sclk, wr_en, wr_flag, wr_ien;
  logic      start, flag_clr;

  clkctl_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni)
  );

  always_comb begin
    wr_key   = bus_we && (bus_addr == A_KEY);
    wr_cfg   = bus_we && (bus_addr == A_OSCCFG);
    wr_sclk  = bus_we && (bus_addr == A_SCLK);
    wr_en    = bus_we && (bus_addr == A_OSCEN);
    wr_flag  = bus_we && (bus_addr == A_FLAG);
    wr_ien   = bus_we && (bus_addr == A_IEN);
    start    = wr_en && bus_wdata[0] && !osc_en;
    flag_clr = wr_flag && bus_wdata[0];
  end

  clkctl_prot u_prot (
    .clk(clk), .rst_n(rst_ni), .wr_key(wr_key), .wdata(bus_wdata),
    .unlocked(unlocked)
  );

  clkctl_regs u_regs (
    .clk(clk), .rst_n(rst_ni), .unlocked(unlocked),
    .wr_cfg(wr_cfg), .wr_sclk(wr_sclk), .wr_en(wr_en), .wr_ien(wr_ien),
    .wdata(bus_wdata[5:0]), .cfg(cfg), .sclk(sclk), .osc_en(osc_en), .ien(ien)
  );

  clkctl_stab #(.WAIT_BASE(WAIT_BASE), .WAIT_STEP(WAIT_STEP), .CODE_W(CODE_W)) u_stab (
    .clk(clk), .rst_n(rst_ni), .osc_en(osc_en), .start(start),
    .flag_clr(flag_clr), .wait_code(cfg.wait_code), .ready(ready)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_KEY:    bus_rdata[0]   = unlocked;
      A_OSCCFG: bus_rdata[5:0] = cfg;
      A_SCLK:   bus_rdata[3:0] = sclk;
      A_OSCEN:  bus_rdata[0]   = osc_en;
      A_FLAG:   bus_rdata[0]   = ready;
      A_IEN:    bus_rdata[0]   = ien;
      default:  bus_rdata      = '0;
    endcase
  end

  assign osc_ready = ready;
  assign osc_irq   = ready && ien;
  assign osc_mode  = cfg.mode;
  assign osc_gain  = cfg.gain;
  assign sys_src   = sclk.src;
  assign sys_div   = sclk.div;

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_clr && !(osc_en && !start && $past(osc_en)) && osc_ready) |=> !osc_ready);
  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !osc_ready |-> !osc_irq);
endmodule

// File: tb/clkctl_top_test.sv
module clkctl_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        osc_ready, osc_irq, osc_mode;
  logic [1:0]  osc_gain, sys_src, sys_div;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  finished = 0;

  bit        m_open;
  logic [5:0] m_cfg;
  logic [3:0] m_sclk;
  logic       m_ien;

  always #2.5 clk = ~clk;

  clkctl_top uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_ready(osc_ready),
    .osc_irq(osc_irq), .osc_mode(osc_mode), .osc_gain(osc_gain),
    .sys_src(sys_src), .sys_div(sys_div)
  );

  function automatic logic [15:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: exp_read = {15'd0, m_open};
      3'd1: exp_read = {10'd0, m_cfg};
      3'd2: exp_read = {12'd0, m_sclk};
      3'd5: exp_read = {15'd0, m_ien};
      default: exp_read = 16'd0;
    endcase
  endfunction

  function automatic int wait_len(input int code);
    wait_len = 1 << (4 + 2 * code);
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic run_wait(input int n, input string tag);
    repeat (n - 1) @(negedge clk);
    check({tag, " not yet"}, {15'd0, osc_ready}, 16'd0);
    @(negedge clk);
    check({tag, " ready"}, {15'd0, osc_ready}, 16'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5eed));
    bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    m_open = 0; m_cfg = 0; m_sclk = 0; m_ien = 0;

    // R3 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R3 reset read", v, 16'd0);
    end
    check("R3 reset src", {14'd0, sys_src}, 16'd0);
    check("R3 reset div", {14'd0, sys_div}, 16'd0);
    check("R3 reset ready/irq", {14'd0, osc_ready, osc_irq}, 16'd0);

    // R2 locked write ignored
    wr(3'd1, 16'h003f);
    wr(3'd2, 16'h000f);
    rd(3'd1, v); check("R2 locked cfg", v, 16'd0);
    rd(3'd2, v); check("R2 locked sclk", v, 16'd0);
    check("R2 locked outputs", {10'd0, osc_mode, osc_gain, sys_src}, 16'd0);

    // R1 R8 R2 random mix
    for (int i = 0; i < 300; i++) begin
      logic [2:0]  a;
      logic [15:0] d;
      case ($urandom % 4)
        0: a = 3'd0;
        1: a = 3'd1;
        2: a = 3'd2;
        default: a = 3'd5;
      endcase
      d = ($urandom % 2) ? 16'h0096 : 16'($urandom);
      if (a == 3'd0 && d == 16'h0096 && ($urandom % 3) == 0) d = 16'h0097;
      wr(a, d);
      case (a)
        3'd0: m_open = (d == 16'h0096);
        3'd1: if (m_open) m_cfg = d[5:0];
        3'd2: if (m_open) m_sclk = d[3:0];
        default: m_ien = d[0];
      endcase
      rd(a, v);
      check("R1/R2/R8/R9 readback", v, exp_read(a));
      check("R8 outputs", {9'd0, osc_mode, osc_gain, sys_div, sys_src},
            {9'd0, m_cfg[5], m_cfg[4:3], m_sclk[3:2], m_sclk[1:0]});
    end

    // R4 code 0
    wr(3'd0, 16'h0096);
    wr(3'd1, 16'h0000); m_cfg = 0;
    wr(3'd0, 16'h0000);
    rd(3'd0, v); check("R1 relocked", v, 16'd0);
    wr(3'd5, 16'h0001);
    wr(3'd3, 16'h0001);
    run_wait(wait_len(0), "R4 code0");
    check("R6 irq on", {15'd0, osc_irq}, 16'd1);
    wr(3'd5, 16'h0000);
    check("R6 irq masked", {15'd0, osc_irq}, 16'd0);
    rd(3'd5, v); check("R9 ien while locked", v, 16'd0);
    wr(3'd4, 16'h0000);
    check("R5 write 0 keeps", {15'd0, osc_ready}, 16'd1);
    wr(3'd4, 16'h0001);
    check("R5 write 1 clears", {15'd0, osc_ready}, 16'd0);
    rd(3'd3, v); check("R9 enable while locked", v, 16'd1);

    // R4 code 2
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'h0096);
    wr(3'd1, 16'h0002);
    wr(3'd0, 16'h1234);
    wr(3'd3, 16'h0001);
    run_wait(wait_len(2), "R4 code2");
    wr(3'd4, 16'h0001);

    // R7 stop and restart with code 1
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'h0096);
    wr(3'd1, 16'h0001);
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0001);
    repeat (30) @(negedge clk);
    wr(3'd3, 16'h0000);
    repeat (100) @(negedge clk);
    check("R7 stopped no flag", {15'd0, osc_ready}, 16'd0);
    wr(3'd3, 16'h0001);
    run_wait(wait_len(1), "R7 restart");
    wr(3'd3, 16'h0000);
    repeat (5) @(negedge clk);
    check("R7 disable keeps flag", {15'd0, osc_ready}, 16'd1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule